// File: doc/BRIEF.md
# Low-Power Mode Transition Controller

This block keeps track of the operating mode of a small processor core. Seven modes exist: high-speed, medium-speed, sub-active, sleep, sub-sleep, software standby and watch. The block changes mode when the core issues a SLEEP instruction, which arrives as a one-cycle strobe, or when a wake event arrives. The mode reached after a SLEEP depends on the current mode and on two flags in the control register. With those flags the core can move straight between the main clock and the subclock without sleeping. The same flags choose which mode follows a release from watch.

The 8-bit control register holds the following fields:
- a direct-transfer flag and a low-speed flag, which steer the mode sequencing;
- a medium-speed select for the running main-clock modes;
- a subclock disable;
- a select for the noise-filter sampling clock;
- a two-bit clock multiplier code.

The block decodes the multiplier code into a factor and the sampling select into a divider value, and drives both as outputs. The oscillators, the multiplier circuit and interrupt arbitration sit outside the block. A wake event comes here already qualified.

Top module: `lpm_mode_ctrl`

## Requirements
- R1: After a synchronous active-low reset, the mode output is high-speed and the register reads 0x01. The multiplier output is then 2 and the sampling divider output is 32. Mode codes: high-speed 0, medium-speed 1, sub-active 2, sleep 3, sub-sleep 4, software standby 5, watch 6.
- R2: A write takes effect at the next clock edge, and a read returns the register with no delay. Bit 7 is direct-transfer, bit 6 is low-speed, bit 5 is fast sampling, bit 4 is subclock disable, bit 3 is medium-speed select and bits 1:0 are the multiplier code. Bit 2 always reads 0.
- R3: A write with multiplier code 11 leaves the multiplier field unchanged. The other bits of that write still take effect.
- R4: The multiplier output is 1, 2 or 4 for codes 00, 01 or 10. The divider output is 32 when bit 5 is 0 and 4 when bit 5 is 1.
- R5: In high-speed or medium-speed mode with no SLEEP taken, the mode follows bit 3 on the cycle after the register changes: 0 gives high-speed, 1 gives medium-speed.
- R6: With standby-select 0, a SLEEP in high-speed or medium-speed mode enters sleep. The exception is when direct-transfer and low-speed are both 1: a SLEEP from high-speed then goes straight to sub-active.
- R7: With standby-select 1, a SLEEP in high-speed or medium-speed mode enters software standby when low-speed is 0. When low-speed is 1, a SLEEP from high-speed enters watch.
- R8: A SLEEP that would enter sub-active or watch is ignored, and the mode is left unchanged, if the current mode is medium-speed or the subclock disable bit is 1.
- R9: In sub-active mode, a SLEEP with standby-select 1 enters watch. With standby-select 0, it goes straight to high-speed when direct-transfer is 1 and low-speed is 0, and enters sub-sleep otherwise.
- R10: A wake event in sleep or software standby returns to the main-clock mode that was held when the SLEEP was taken. A wake event in sub-sleep returns to sub-active.
- R11: A wake event in watch enters high-speed when low-speed is 0 and sub-active when low-speed is 1.
- R12: A SLEEP strobe in sleep, sub-sleep, standby or watch has no effect on the mode. A wake event in high-speed, medium-speed or sub-active has no effect on the mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en_i | input | 1 | Control register write strobe |
| wr_data_i | input | 8 | Control register write data |
| rd_data_o | output | 8 | Control register read data |
| sleep_i | input | 1 | One-cycle SLEEP instruction strobe |
| standby_sel_i | input | 1 | 0: sleep-type target, 1: standby or watch target |
| wake_i | input | 1 | Qualified wake-up event |
| mode_o | output | 3 | Current operating mode code |
| mult_o | output | 3 | Clock multiplication factor (1, 2 or 4) |
| smp_div_o | output | 6 | Noise-filter sampling divider (32 or 4) |

## Verification
On every cycle, the assertions check these properties:
- the multiplier field never holds the reserved code, and a write of that code leaves the field unchanged;
- the multiplier factor has exactly one bit set;
- a dormant mode holds until a wake event arrives;
- sub-sleep always wakes into sub-active, and watch wakes into high-speed when low-speed is 0;
- medium-speed never moves to sub-active or watch.

Some behaviours are shown only by the bench's scenario sequences. These are the full decision table of SLEEP targets over both flags and standby-select, the return to the saved main-clock mode after sleep or standby, the one-cycle lag of the medium-speed select, and the read-back of each register field.

// File: rtl/lpm_pkg.sv
// Package with the types shared by the mode controller: the mode codes, the
// layout of the control register and its reset value.
// Assumes an 8-bit register with the field order the sequencing logic relies on.
package lpm_pkg;

    typedef enum logic [2:0] {
        MODE_HIGH     = 3'd0,
        MODE_MED      = 3'd1,
        MODE_SUBACT   = 3'd2,
        MODE_SLEEP    = 3'd3,
        MODE_SUBSLEEP = 3'd4,
        MODE_STANDBY  = 3'd5,
        MODE_WATCH    = 3'd6
    } lpm_mode_e;

    typedef struct packed {
        logic       direct;    // bit 7: direct transfer between main clock and subclock
        logic       lowspd;    // bit 6: prefer the subclock side
        logic       fast_smp;  // bit 5: fast noise-filter sampling
        logic       sub_off;   // bit 4: subclock disabled
        logic       med_sel;   // bit 3: medium-speed select
        logic       rsvd;      // bit 2: always zero
        logic [1:0] mult;      // bits 1:0: multiplier code
    } lpm_ctl_t;

    localparam logic [1:0] MULT_RSVD = 2'b11;
    localparam lpm_ctl_t   CTL_RESET = '{direct: 1'b0, lowspd: 1'b0, fast_smp: 1'b0,
                                         sub_off: 1'b0, med_sel: 1'b0, rsvd: 1'b0,
                                         mult: 2'b01};

endpackage

// File: rtl/lpm_ctrl_reg.sv
// Control register of the mode controller.
// What it does: takes a full-width write and keeps the multiplier field
// unchanged when the reserved code is written. Bit 2 is forced to zero.
// Assumes a synchronous active-low reset and one writer.
module lpm_ctrl_reg
    import lpm_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [DATA_W-1:0] wr_data_i,
    output lpm_ctl_t          ctl_o,
    output logic [DATA_W-1:0] rd_data_o
);

    lpm_ctl_t ctl_q;
    lpm_ctl_t wr_view;

    // Interpret the write data with the register layout.
    assign wr_view = lpm_ctl_t'(wr_data_i[$bits(lpm_ctl_t)-1:0]);

    // Register update: field-wise load, reserved multiplier code filtered out.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= CTL_RESET;
        end else if (wr_en_i) begin
            ctl_q.direct   <= wr_view.direct;
            ctl_q.lowspd   <= wr_view.lowspd;
            ctl_q.fast_smp <= wr_view.fast_smp;
            ctl_q.sub_off  <= wr_view.sub_off;
            ctl_q.med_sel  <= wr_view.med_sel;
            ctl_q.rsvd     <= 1'b0;
            ctl_q.mult     <= (wr_view.mult == MULT_RSVD) ? ctl_q.mult : wr_view.mult;
        end
    end

    assign ctl_o     = ctl_q;
    assign rd_data_o = DATA_W'(ctl_q);

    // R3: the reserved multiplier code is never stored.
    p_mult_legal_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_q.mult != MULT_RSVD);

    // R3: a write of the reserved code leaves the field as it was.
    p_rsvd_keep_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && wr_data_i[1:0] == MULT_RSVD) |=> $stable(ctl_q.mult));

    // R2: bit 2 always reads zero.
    p_bit2_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data_o[2] == 1'b0);

endmodule

// File: rtl/lpm_clk_sel.sv
// Decodes the clock-related register fields into output values.
// What it does: the multiplier code becomes a one-hot factor and the
// sampling select becomes a divider value.
// Assumes the register never holds the reserved multiplier code.
module lpm_clk_sel
    import lpm_pkg::*;
#(
    parameter int MULT_W   = 3,
    parameter int DIV_W    = 6,
    parameter int DIV_SLOW = 32,
    parameter int DIV_FAST = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  lpm_ctl_t          ctl_i,
    output logic [MULT_W-1:0] mult_o,
    output logic [DIV_W-1:0]  smp_div_o
);

    // Multiplier factor: a power of two given by the code.
    always_comb begin
        mult_o = MULT_W'(1) << ctl_i.mult;
    end

    // Sampling divider selection.
    always_comb begin
        smp_div_o = ctl_i.fast_smp ? DIV_W'(DIV_FAST) : DIV_W'(DIV_SLOW);
    end

    // R4: the factor is always a single power of two.
    p_mult_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(mult_o) == 1);

endmodule

// File: rtl/lpm_next_mode.sv
// Combinational next-mode decision of the controller.
// What it does: from the current mode, the strobes and the register flags it
// gives the next mode. It also flags when the current main-clock mode must be
// saved for the later return.
// Assumes the SLEEP strobe and the wake event are single-cycle and already qualified.
module lpm_next_mode
    import lpm_pkg::*;
(
    input  lpm_mode_e cur_i,
    input  lpm_mode_e saved_i,
    input  logic      sleep_i,
    input  logic      stby_i,
    input  logic      wake_i,
    input  lpm_ctl_t  ctl_i,
    output lpm_mode_e nxt_o,
    output logic      save_o
);

    logic sub_ok;

    // A move onto the subclock side needs high-speed and a running subclock.
    assign sub_ok = (cur_i == MODE_HIGH) && !ctl_i.sub_off;

    // Mode decision table.
    always_comb begin
        nxt_o  = cur_i;
        save_o = 1'b0;
        unique case (cur_i)
            MODE_HIGH, MODE_MED: begin
                nxt_o = ctl_i.med_sel ? MODE_MED : MODE_HIGH;
                if (sleep_i) begin
                    if (!stby_i) begin
                        if (ctl_i.direct && ctl_i.lowspd) begin
                            if (sub_ok) nxt_o = MODE_SUBACT;
                        end else begin
                            nxt_o  = MODE_SLEEP;
                            save_o = 1'b1;
                        end
                    end else begin
                        if (ctl_i.lowspd) begin
                            if (sub_ok) nxt_o = MODE_WATCH;
                        end else begin
                            nxt_o  = MODE_STANDBY;
                            save_o = 1'b1;
                        end
                    end
                end
            end
            MODE_SUBACT: begin
                if (sleep_i) begin
                    if (stby_i)                              nxt_o = MODE_WATCH;
                    else if (ctl_i.direct && !ctl_i.lowspd)  nxt_o = MODE_HIGH;
                    else                                     nxt_o = MODE_SUBSLEEP;
                end
            end
            MODE_SLEEP, MODE_STANDBY: begin
                if (wake_i) nxt_o = saved_i;
            end
            MODE_SUBSLEEP: begin
                if (wake_i) nxt_o = MODE_SUBACT;
            end
            MODE_WATCH: begin
                if (wake_i) nxt_o = ctl_i.lowspd ? MODE_SUBACT : MODE_HIGH;
            end
            default: nxt_o = MODE_HIGH;
        endcase
    end

endmodule

// File: rtl/lpm_mode_fsm.sv
// Mode state register and the saved main-clock mode.
// What it does: loads the decided next mode every cycle. It records the
// running main-clock mode whenever sleep or standby is entered.
// Assumes the next-mode decision comes from lpm_next_mode.
module lpm_mode_fsm
    import lpm_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  lpm_mode_e nxt_i,
    input  logic      save_i,
    output lpm_mode_e mode_o,
    output lpm_mode_e saved_o
);

    lpm_mode_e mode_q;
    lpm_mode_e saved_q;

    // Current mode register.
    always_ff @(posedge clk) begin
        if (!rst_n) mode_q <= MODE_HIGH;
        else        mode_q <= nxt_i;
    end

    // Return slot for sleep and standby.
    always_ff @(posedge clk) begin
        if (!rst_n)      saved_q <= MODE_HIGH;
        else if (save_i) saved_q <= mode_q;
    end

    assign mode_o  = mode_q;
    assign saved_o = saved_q;

    // R10: the return slot only ever holds a main-clock mode.
    p_saved_main_r10: assert property (@(posedge clk) disable iff (!rst_n)
        saved_q == MODE_HIGH || saved_q == MODE_MED);

endmodule

// File: rtl/lpm_mode_ctrl.sv
// Top of the low-power mode transition controller.
// What it does: joins the control register, the clock-field decode, the
// next-mode decision and the mode register.
// Assumes sleep_i and wake_i are single-cycle strobes synchronous to clk.
module lpm_mode_ctrl
    import lpm_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int MAX_MULT = 4,
    parameter int DIV_SLOW = 32,
    parameter int DIV_FAST = 4,
    localparam int MULT_W  = $clog2(MAX_MULT + 1),
    localparam int DIV_W   = $clog2(DIV_SLOW + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [DATA_W-1:0] wr_data_i,
    output logic [DATA_W-1:0] rd_data_o,
    input  logic              sleep_i,
    input  logic              standby_sel_i,
    input  logic              wake_i,
    output logic [2:0]        mode_o,
    output logic [MULT_W-1:0] mult_o,
    output logic [DIV_W-1:0]  smp_div_o
);

    lpm_ctl_t  ctl;
    lpm_mode_e mode_cur;
    lpm_mode_e mode_saved;
    lpm_mode_e mode_nxt;
    logic      save_main;

    lpm_ctrl_reg #(.DATA_W(DATA_W)) u_reg (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en_i),
        .wr_data_i (wr_data_i),
        .ctl_o     (ctl),
        .rd_data_o (rd_data_o)
    );

    lpm_clk_sel #(
        .MULT_W   (MULT_W),
        .DIV_W    (DIV_W),
        .DIV_SLOW (DIV_SLOW),
        .DIV_FAST (DIV_FAST)
    ) u_clk (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctl_i     (ctl),
        .mult_o    (mult_o),
        .smp_div_o (smp_div_o)
    );

    lpm_next_mode u_nxt (
        .cur_i   (mode_cur),
        .saved_i (mode_saved),
        .sleep_i (sleep_i),
        .stby_i  (standby_sel_i),
        .wake_i  (wake_i),
        .ctl_i   (ctl),
        .nxt_o   (mode_nxt),
        .save_o  (save_main)
    );

    lpm_mode_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .nxt_i   (mode_nxt),
        .save_i  (save_main),
        .mode_o  (mode_cur),
        .saved_o (mode_saved)
    );

    assign mode_o = mode_cur;

    // R12: a dormant mode holds until a wake event arrives.
    p_dormant_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode_cur == MODE_SLEEP || mode_cur == MODE_SUBSLEEP ||
          mode_cur == MODE_STANDBY || mode_cur == MODE_WATCH) && !wake_i)
        |=> $stable(mode_cur));

    // R10: sub-sleep always wakes into sub-active.
    p_subsleep_wake_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_cur == MODE_SUBSLEEP && wake_i) |=> mode_cur == MODE_SUBACT);

    // R11: leaving watch with the low-speed flag clear lands in high-speed.
    p_watch_exit_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_cur == MODE_WATCH && wake_i && !ctl.lowspd) |=> mode_cur == MODE_HIGH);

    // R8: medium-speed never moves onto the subclock side.
    p_med_guard_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_cur == MODE_MED) |=> (mode_cur != MODE_SUBACT && mode_cur != MODE_WATCH));

    // R1: only the seven defined mode codes appear.
    p_mode_legal_r1: assert property (@(posedge clk) disable iff (!rst_n)
        mode_o != 3'd7);

endmodule

// File: tb/lpm_mode_ctrl_tb.sv
// Scoreboard bench: the step task drives one cycle and queues the expected
// outputs; the monitor compares them just after the clock edge.
module lpm_mode_ctrl_tb;

    typedef struct packed {
        logic [2:0] mode;
        logic [7:0] rd;
        logic [2:0] mult;
        logic [5:0] div;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;
    logic       sleep = 1'b0;
    logic       stby = 1'b0;
    logic       wake = 1'b0;
    logic [2:0] mode;
    logic [2:0] mult;
    logic [5:0] sdiv;

    int total = 0;
    int bad = 0;
    logic [7:0] exp_reg = 8'h01;
    exp_t  exp_q[$];
    string tag_q[$];

    localparam logic [2:0] HI = 3'd0, MD = 3'd1, SA = 3'd2, SL = 3'd3,
                           SS = 3'd4, SB = 3'd5, WT = 3'd6;

    always #5 clk = ~clk;

    lpm_mode_ctrl u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .wr_en_i       (wr_en),
        .wr_data_i     (wr_data),
        .rd_data_o     (rd_data),
        .sleep_i       (sleep),
        .standby_sel_i (stby),
        .wake_i        (wake),
        .mode_o        (mode),
        .mult_o        (mult),
        .smp_div_o     (sdiv)
    );

    function automatic logic [2:0] mult_of(input logic [1:0] c);
        return (c == 2'b00) ? 3'd1 : (c == 2'b01) ? 3'd2 : 3'd4;
    endfunction

    task automatic check(input string tag, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // One cycle of stimulus; expected values are queued for the monitor.
    task automatic step(input logic slp, input logic sb, input logic wk, input logic we,
                        input logic [7:0] wd, input logic [2:0] em, input string tag);
        exp_t e;
        @(negedge clk);
        sleep = slp; stby = sb; wake = wk; wr_en = we; wr_data = wd;
        if (we)
            exp_reg = {wd[7:3], 1'b0, (wd[1:0] == 2'b11) ? exp_reg[1:0] : wd[1:0]};
        e.mode = em;
        e.rd   = exp_reg;
        e.mult = mult_of(exp_reg[1:0]);
        e.div  = exp_reg[5] ? 6'd4 : 6'd32;
        exp_q.push_back(e);
        tag_q.push_back(tag);
        @(posedge clk);
        #1;
        sleep = 1'b0; stby = 1'b0; wake = 1'b0; wr_en = 1'b0;
    endtask

    // Monitor: pops one expectation per edge while any are pending.
    always @(posedge clk) begin
        #2;
        if (exp_q.size() > 0) begin
            exp_t  e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(t, "mode", int'(mode), int'(e.mode));
            check(t, "rd_data", int'(rd_data), int'(e.rd));
            check(t, "mult", int'(mult), int'(e.mult));
            check(t, "smp_div", int'(sdiv), int'(e.div));
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        step(0, 0, 0, 0, 8'h00, HI, "R1");
        // R2, R4: field writes and decoded outputs
        step(0, 0, 0, 1, 8'h20, HI, "R4");
        step(0, 0, 0, 1, 8'h02, HI, "R4");
        step(0, 0, 0, 1, 8'h23, HI, "R3");
        step(0, 0, 0, 1, 8'hF5, HI, "R2");
        step(0, 0, 0, 1, 8'h01, HI, "R2");
        // R8: subclock disabled blocks sub-active and watch
        step(0, 0, 0, 1, 8'hD1, HI, "R2");
        step(1, 0, 0, 0, 8'h00, HI, "R8");
        step(1, 1, 0, 0, 8'h00, HI, "R8");
        // R6 plain sleep and return
        step(0, 0, 0, 1, 8'h01, HI, "R2");
        step(1, 0, 0, 0, 8'h00, SL, "R6");
        step(1, 0, 0, 0, 8'h00, SL, "R12");
        step(0, 0, 1, 0, 8'h00, HI, "R10");
        step(0, 0, 1, 0, 8'h00, HI, "R12");
        // direct transfer to sub-active and the sub-active decisions
        step(0, 0, 0, 1, 8'hC1, HI, "R2");
        step(1, 0, 0, 0, 8'h00, SA, "R6");
        step(0, 0, 1, 0, 8'h00, SA, "R12");
        step(1, 0, 0, 0, 8'h00, SS, "R9");
        step(0, 0, 1, 0, 8'h00, SA, "R10");
        step(0, 0, 0, 1, 8'h81, SA, "R9");
        step(1, 0, 0, 0, 8'h00, HI, "R9");
        // watch entry and exit
        step(0, 0, 0, 1, 8'h41, HI, "R2");
        step(1, 1, 0, 0, 8'h00, WT, "R7");
        step(0, 0, 1, 0, 8'h00, SA, "R11");
        step(1, 1, 0, 0, 8'h00, WT, "R9");
        step(0, 0, 0, 1, 8'h01, WT, "R12");
        step(0, 0, 1, 0, 8'h00, HI, "R11");
        // medium-speed select, the return slot and the high-speed-only rule
        step(0, 0, 0, 1, 8'h09, HI, "R5");
        step(0, 0, 0, 0, 8'h00, MD, "R5");
        step(1, 0, 0, 0, 8'h00, SL, "R6");
        step(0, 0, 1, 0, 8'h00, MD, "R10");
        step(0, 0, 0, 1, 8'h49, MD, "R2");
        step(1, 1, 0, 0, 8'h00, MD, "R8");
        step(0, 0, 0, 1, 8'hC9, MD, "R2");
        step(1, 0, 0, 0, 8'h00, MD, "R8");
        step(0, 0, 0, 1, 8'h09, MD, "R2");
        step(1, 1, 0, 0, 8'h00, SB, "R7");
        step(1, 1, 0, 0, 8'h00, SB, "R12");
        step(0, 0, 1, 0, 8'h00, MD, "R10");
        step(0, 0, 0, 1, 8'h01, MD, "R5");
        step(0, 0, 0, 0, 8'h00, HI, "R5");
        repeat (3) @(posedge clk);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule